// File: doc/BRIEF.md
# Two-Wire Debug Target Responder

This block is the target end of a two-wire serial debug link. It runs on the link clock. Each rising edge samples one host bit from the data line. Outputs that the target drives change just after a rising edge. The host changes its bits on the falling edge, so every sampled bit is stable when it is taken.

A transaction has four parts:
- A start bit opens the transaction.
- Seven header bits follow the start bit. The block checks them and decodes which port is addressed, the direction and a 2-bit register address.
- After one turnaround cycle the target drives a 3-bit acknowledge.
- A data phase follows. On a read the target drives 33 bits. On a write the host sends 33 bits after a second turnaround cycle.

Debug-port requests reach a local register set. This set holds an identifier, a control/status word, a select word and an abort command. Access-port requests go to a parallel port that has a ready input. A write-data parity error sets a sticky error. While that error is set, only three accesses are answered. All other requests are refused until software clears the error through the abort register.

Top module: `dbgport_tgt`

## Requirements
- R1: A header is accepted only if all of these hold: start = 1, stop = 0, park = 1, and the parity bit equals the XOR of the port, direction and two address bits. If any of these fails, the target drives nothing and waits for the next start bit.
- R2: Header bits arrive in this order: start, port (1 = access port), direction (1 = read), A2, A3, parity, stop, park. All multi-bit fields are sent least significant bit first.
- R3: Exactly one undriven cycle follows the park bit. The target then drives a 3-bit acknowledge, bit 0 first. The codes are OK = 001, WAIT = 010 and FAULT = 100. After WAIT or FAULT there is one undriven cycle and no data phase.
- R4: On an OK read, the target drives 32 data bits LSB first. It then drives a parity bit equal to the XOR of the data. One undriven cycle follows.
- R5: On an OK write, the line is undriven for one cycle after the acknowledge. The target then samples 32 data bits LSB first, followed by a parity bit.
- R6: Debug-port address map, with the address written as {A3,A2}:
  - 00: a read returns the parameter ID_VAL; a write goes to abort.
  - 01: control/status.
  - 10: select.
  - 11: a read returns zero; a write is ignored.
- R7: Control/status holds the sticky error in bit 1. Bits [31:24] are a read/write field. All other bits read zero.
- R8: A write whose data parity is wrong has no effect on any register or on the access port, and it sets the sticky error.
- R9: While the sticky error is set, only three accesses get OK: a read of address 00, a read of address 01, and a write to address 00. Every other request gets FAULT, and no access-port request is made.
- R10: An abort write with bit 2 set clears the sticky error. An abort write with bit 2 clear leaves it set.
- R11: Each access-port transfer raises ap_req_o for exactly one cycle.
  - A read request is raised in the turnaround after the header, and ap_rdata_i is taken in that cycle.
  - A write request is raised in the parity cycle, with ap_we_o = 1.
  - ap_addr_o is {select[7:4], A3, A2}.
- R12: If ap_ready_i is low in the turnaround cycle of an access-port request, the acknowledge is WAIT and no request is raised.
- R13: After reset, the line is undriven, the sticky error is clear, and select reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dio_i | input | 1 | Data line as seen by the target |
| dio_o | output | 1 | Value the target drives onto the data line |
| dio_oe_o | output | 1 | Target owns the data line |
| ap_req_o | output | 1 | One-cycle access-port request |
| ap_we_o | output | 1 | Access-port request is a write |
| ap_addr_o | output | BANK_W+2 | Access-port register address {bank, A3, A2} |
| ap_wdata_o | output | DATA_W | Access-port write data |
| ap_rdata_i | input | DATA_W | Access-port read data, taken in the request cycle |
| ap_ready_i | input | 1 | Access port can take a request |

## Verification
The assertions assume the host behaves as a well-formed bus master:
- It changes dio_i only at falling edges.
- It never starts a new header while the target is driving or in a turnaround.
- ap_ready_i is a level that holds for a whole transaction.

The bench drives the line only from its host task at falling edges. It holds the line low between transactions and changes ap_ready_i only between transactions. Malformed headers and bad write parity are produced only by corrupting single bits inside that same host sequence.

// File: rtl/dbgport_pkg.sv
package dbgport_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_TRN1, ST_ACK, ST_RDATA, ST_TRN2, ST_WDATA
  } st_e;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  localparam int HDR_BITS = 7;  // header bits after start
  localparam int ERR_BIT  = 1;  // sticky error in control/status
  localparam int CLR_BIT  = 2;  // abort error-clear
  localparam int BANK_LSB = 4;  // bank field in select

  typedef struct packed {
    logic       ap;
    logic       rd;
    logic [1:0] addr;  // {A3, A2}
  } req_t;
endpackage

// File: rtl/dbgport_hdr_chk.sv
module dbgport_hdr_chk
  import dbgport_pkg::*;
(
  input  logic [HDR_BITS-1:0] bits_i,
  output logic                ok_o,
  output req_t                req_o
);
  always_comb begin
    req_o.ap   = bits_i[0];
    req_o.rd   = bits_i[1];
    req_o.addr = {bits_i[3], bits_i[2]};
    ok_o = (bits_i[4] == ^bits_i[3:0]) && !bits_i[5] && bits_i[6];
  end
endmodule

// File: rtl/dbgport_dp_regs.sv
module dbgport_dp_regs
  import dbgport_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter int          CTRL_W = 8,
  parameter int          BANK_W = 4,
  parameter logic [31:0] ID_VAL = 32'h0C0D_E5A1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              par_err_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic [BANK_W-1:0] bank_o
);
  logic              err_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      ctrl_q <= '0;
      sel_q  <= '0;
    end else if (par_err_i) begin
      err_q <= 1'b1;
    end else if (wr_i) begin
      case (addr_i)
        2'b00:   if (wdata_i[CLR_BIT]) err_q <= 1'b0;
        2'b01:   ctrl_q <= wdata_i[DATA_W-1 -: CTRL_W];
        2'b10:   sel_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      2'b00: rdata_o = DATA_W'(ID_VAL);
      2'b01: begin
        rdata_o[DATA_W-1 -: CTRL_W] = ctrl_q;
        rdata_o[ERR_BIT]            = err_q;
      end
      2'b10:   rdata_o = sel_q;
      default: rdata_o = '0;
    endcase
  end

  assign err_o  = err_q;
  assign bank_o = sel_q[BANK_LSB +: BANK_W];
endmodule

// File: rtl/dbgport_tgt.sv
module dbgport_tgt
  import dbgport_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter int          CTRL_W = 8,
  parameter int          BANK_W = 4,
  parameter logic [31:0] ID_VAL = 32'h0C0D_E5A1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dio_i,
  output logic              dio_o,
  output logic              dio_oe_o,
  output logic              ap_req_o,
  output logic              ap_we_o,
  output logic [BANK_W+1:0] ap_addr_o,
  output logic [DATA_W-1:0] ap_wdata_o,
  input  logic [DATA_W-1:0] ap_rdata_i,
  input  logic              ap_ready_i
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BITS - 1);

  st_e                 st_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [HDR_BITS-1:0] hdr_q, hdr_nxt;
  req_t                req_q, hdr_req;
  logic [2:0]          ack_q, ack_nxt;
  logic [DATA_W-1:0]   sh_q, rd_val, dp_rdata;
  logic                par_q, hdr_ok, err_q, fault_ok;
  logic                wr_done, par_good, dp_wr, par_err, ap_rd_go;
  logic [BANK_W-1:0]   bank;

  assign hdr_nxt = {dio_i, hdr_q[HDR_BITS-1:1]};

  dbgport_hdr_chk u_hdr (
    .bits_i(hdr_nxt),
    .ok_o  (hdr_ok),
    .req_o (hdr_req)
  );

  dbgport_dp_regs #(
    .DATA_W(DATA_W), .CTRL_W(CTRL_W), .BANK_W(BANK_W), .ID_VAL(ID_VAL)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (dp_wr),
    .addr_i   (req_q.addr),
    .wdata_i  (sh_q),
    .par_err_i(par_err),
    .rdata_o  (dp_rdata),
    .err_o    (err_q),
    .bank_o   (bank)
  );

  // accesses still answered while the sticky error is set
  assign fault_ok = !req_q.ap &&
                    ((req_q.rd && !req_q.addr[1]) || (!req_q.rd && req_q.addr == 2'b00));

  always_comb begin
    if (err_q && !fault_ok)          ack_nxt = ACK_FAULT;
    else if (req_q.ap && !ap_ready_i) ack_nxt = ACK_WAIT;
    else                             ack_nxt = ACK_OK;
  end

  assign rd_val   = req_q.ap ? ap_rdata_i : dp_rdata;
  assign ap_rd_go = (st_q == ST_TRN1) && req_q.ap && req_q.rd && (ack_nxt == ACK_OK);
  assign wr_done  = (st_q == ST_WDATA) && (cnt_q == CNT_LAST);
  assign par_good = (dio_i == ^sh_q);
  assign dp_wr    = wr_done && par_good && !req_q.ap;
  assign par_err  = wr_done && !par_good;

  assign ap_req_o   = ap_rd_go || (wr_done && par_good && req_q.ap);
  assign ap_we_o    = (st_q == ST_WDATA);
  assign ap_addr_o  = {bank, req_q.addr};
  assign ap_wdata_o = sh_q;

  assign dio_oe_o = (st_q == ST_ACK) || (st_q == ST_RDATA);
  always_comb begin
    case (st_q)
      ST_ACK:   dio_o = ack_q[cnt_q[1:0]];
      ST_RDATA: dio_o = (cnt_q == CNT_LAST) ? par_q : sh_q[0];
      default:  dio_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      hdr_q <= '0;
      req_q <= '0;
      ack_q <= ACK_OK;
      sh_q  <= '0;
      par_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (dio_i) begin
          st_q  <= ST_HDR;
          cnt_q <= '0;
        end
        ST_HDR: begin
          hdr_q <= hdr_nxt;
          if (cnt_q == HDR_LAST) begin
            cnt_q <= '0;
            req_q <= hdr_req;
            st_q  <= hdr_ok ? ST_TRN1 : ST_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_TRN1: begin
          ack_q <= ack_nxt;
          sh_q  <= rd_val;
          par_q <= ^rd_val;
          cnt_q <= '0;
          st_q  <= ST_ACK;
        end
        ST_ACK: begin
          if (cnt_q == CNT_W'(2)) begin
            cnt_q <= '0;
            st_q  <= (ack_q == ACK_OK && req_q.rd) ? ST_RDATA : ST_TRN2;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_RDATA: begin
          if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            st_q  <= ST_TRN2;
          end else begin
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_TRN2: begin
          cnt_q <= '0;
          st_q  <= (ack_q == ACK_OK && !req_q.rd) ? ST_WDATA : ST_IDLE;
        end
        ST_WDATA: begin
          if (cnt_q == CNT_LAST) begin
            st_q <= ST_IDLE;
          end else begin
            sh_q  <= {dio_i, sh_q[DATA_W-1:1]};
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

module dbgport_tgt_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dio_oe_o,
  input logic ap_req_o,
  input logic ap_we_o,
  input logic ap_ready_i,
  input logic err_q
);
  // R11
  ap_req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_req_o |=> !ap_req_o);
  // R12
  ap_rd_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ap_req_o && !ap_we_o) |-> ap_ready_i);
  // R9
  ap_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_req_o |-> !err_q);
  // R3
  ack_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dio_oe_o) |=> dio_oe_o);
  // R5
  wr_undriven_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ap_req_o && ap_we_o) |-> !dio_oe_o);
endmodule

bind dbgport_tgt dbgport_tgt_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dio_oe_o  (dio_oe_o),
  .ap_req_o  (ap_req_o),
  .ap_we_o   (ap_we_o),
  .ap_ready_i(ap_ready_i),
  .err_q     (err_q)
);

// File: tb/dbgport_tgt_test.sv
module dbgport_tgt_test;
  localparam logic [31:0] ID = 32'h0C0D_E5A1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dio_i = 1'b0;
  logic        dio_o, dio_oe_o, ap_req_o, ap_we_o;
  logic [5:0]  ap_addr_o;
  logic [31:0] ap_wdata_o;
  logic [31:0] ap_rdata_i = 32'h0;
  logic        ap_ready_i = 1'b1;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [2:0]  ack_r;
  logic [31:0] rdata_r, wr_data_r;
  logic        rpar_r, oe_any, oe_trn, rd_req_seen, wr_req_seen;
  logic [5:0]  rd_addr_r, wr_addr_r;

  always #10 clk_i = ~clk_i;

  dbgport_tgt uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .dio_i(dio_i), .dio_o(dio_o),
    .dio_oe_o(dio_oe_o), .ap_req_o(ap_req_o), .ap_we_o(ap_we_o),
    .ap_addr_o(ap_addr_o), .ap_wdata_o(ap_wdata_o),
    .ap_rdata_i(ap_rdata_i), .ap_ready_i(ap_ready_i)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic slot(input logic b);
    @(negedge clk_i);
    dio_i = b;
    #1;
  endtask

  // bad_hdr: 0 none, 1 parity, 2 stop, 3 park
  task automatic xfer(input logic ap, input logic rd, input logic [1:0] a,
                      input logic [31:0] wd, input int bad_hdr, input logic bad_par);
    logic [7:0] hb;
    hb = {bad_hdr != 3, bad_hdr == 2, (ap ^ rd ^ a[0] ^ a[1]) ^ (bad_hdr == 1),
          a[1], a[0], rd, ap, 1'b1};
    oe_any = 0; rd_req_seen = 0; wr_req_seen = 0; ack_r = '0; rdata_r = '0;
    for (int s = 0; s < 8; s++) begin slot(hb[s]); oe_any |= dio_oe_o; end
    slot(1'b0);
    oe_trn = dio_oe_o;
    if (ap_req_o) begin rd_req_seen = !ap_we_o; rd_addr_r = ap_addr_o; end
    for (int k = 0; k < 3; k++) begin
      slot(1'b0); ack_r[k] = dio_o & dio_oe_o; oe_any |= dio_oe_o;
    end
    if (ack_r == 3'b001 && rd) begin
      for (int k = 0; k < 32; k++) begin slot(1'b0); rdata_r[k] = dio_o; end
      slot(1'b0); rpar_r = dio_o;
      slot(1'b0); oe_trn |= dio_oe_o;
    end else begin
      slot(1'b0); oe_trn |= dio_oe_o;
      if (ack_r == 3'b001) begin
        for (int k = 0; k < 32; k++) begin
          slot(wd[k]); oe_trn |= dio_oe_o;
        end
        slot((^wd) ^ bad_par);
        if (ap_req_o) begin
          wr_req_seen = ap_we_o; wr_data_r = ap_wdata_o; wr_addr_r = ap_addr_o;
        end
      end
    end
    slot(1'b0); slot(1'b0);
  endtask

  task automatic t_reset;
    check(!dio_oe_o && !ap_req_o, "R13 line idle after reset", dio_oe_o, 0);
    xfer(0, 1, 2'b10, 0, 0, 0);
    check(ack_r == 3'b001 && rdata_r == 0, "R13 select zero", rdata_r, 0);
  endtask

  task automatic t_id_read;
    xfer(0, 1, 2'b00, 0, 0, 0);
    check(!oe_trn, "R3 turnarounds undriven", oe_trn, 0);
    check(ack_r == 3'b001, "R3 ack OK", ack_r, 1);
    check(rdata_r == ID, "R4 R6 id read", rdata_r, ID);
    check(rpar_r == ^ID, "R4 read parity", rpar_r, ^ID);
  endtask

  task automatic t_select_rw;
    xfer(0, 0, 2'b10, 32'h0000_00A5, 0, 0);
    check(ack_r == 3'b001 && !oe_trn, "R5 write ack and turnaround", ack_r, 1);
    xfer(0, 1, 2'b10, 0, 0, 0);
    check(rdata_r == 32'h0000_00A5, "R6 select readback", rdata_r, 32'hA5);
    xfer(0, 0, 2'b11, 32'hFFFF_FFFF, 0, 0);
    xfer(0, 1, 2'b11, 0, 0, 0);
    check(rdata_r == 0, "R6 address 11 reads zero", rdata_r, 0);
    xfer(0, 0, 2'b01, 32'h5A00_0000, 0, 0);
    xfer(0, 1, 2'b01, 0, 0, 0);
    check(rdata_r == 32'h5A00_0000, "R7 control field", rdata_r, 32'h5A00_0000);
  endtask

  task automatic t_ap;
    ap_rdata_i = 32'h1357_9BDF;
    xfer(1, 1, 2'b11, 0, 0, 0);
    check(rd_req_seen && rd_addr_r == 6'b1010_11, "R11 AP read request", rd_addr_r, 6'h2B);
    check(rdata_r == 32'h1357_9BDF && rpar_r == ^32'h1357_9BDF, "R11 AP read data",
          rdata_r, 32'h1357_9BDF);
    xfer(1, 0, 2'b01, 32'hCAFE_0001, 0, 0);
    check(wr_req_seen && wr_data_r == 32'hCAFE_0001 && wr_addr_r == 6'b1010_01,
          "R11 AP write", wr_data_r, 32'hCAFE_0001);
    ap_ready_i = 1'b0;
    xfer(1, 1, 2'b00, 0, 0, 0);
    check(ack_r == 3'b010 && !rd_req_seen && !oe_trn, "R12 WAIT", ack_r, 3'b010);
    ap_ready_i = 1'b1;
  endtask

  task automatic t_bad_hdr;
    for (int m = 1; m <= 3; m++) begin
      xfer(0, 1, 2'b00, 0, m, 0);
      check(!oe_any && !oe_trn, "R1 R2 bad header no response", oe_any, 0);
    end
    xfer(0, 1, 2'b00, 0, 0, 0);
    check(ack_r == 3'b001 && rdata_r == ID, "R1 recovers", rdata_r, ID);
  endtask

  task automatic t_fault;
    xfer(0, 0, 2'b10, 32'h0000_0FF0, 0, 1);
    xfer(0, 1, 2'b01, 0, 0, 0);
    check(ack_r == 3'b001 && rdata_r[1], "R8 R7 sticky set", rdata_r, 32'h5A00_0002);
    xfer(0, 1, 2'b10, 0, 0, 0);
    check(ack_r == 3'b100 && !oe_trn, "R9 select read refused", ack_r, 3'b100);
    xfer(1, 1, 2'b00, 0, 0, 0);
    check(ack_r == 3'b100 && !rd_req_seen, "R9 AP blocked", ack_r, 3'b100);
    xfer(0, 1, 2'b00, 0, 0, 0);
    check(ack_r == 3'b001 && rdata_r == ID, "R9 id read allowed", rdata_r, ID);
    xfer(0, 0, 2'b00, 32'h0000_0001, 0, 0);
    check(ack_r == 3'b001, "R9 abort allowed", ack_r, 1);
    xfer(0, 1, 2'b01, 0, 0, 0);
    check(rdata_r[1], "R10 no clear without bit2", rdata_r, 32'h2);
    xfer(0, 0, 2'b00, 32'h0000_0004, 0, 0);
    xfer(0, 1, 2'b10, 0, 0, 0);
    check(ack_r == 3'b001 && rdata_r == 32'hA5, "R10 R8 cleared, write discarded",
          rdata_r, 32'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset;
    t_id_read;
    t_select_rw;
    t_ap;
    t_bad_hdr;
    t_fault;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule